// File: doc/BRIEF.md
# Sliding Mask Register with Masked Compare and Masked Merge

This block holds a wide bit mask with two uses. For a search it marks which bit positions take part: a mask bit of 0 makes the position count, and a mask bit of 1 makes the comparison ignore it. For a write or move into a destination word it acts as an inverted per-bit write enable. New data lands where the mask is 0, and the old value is kept where the mask is 1. Software-facing logic elsewhere loads the mask one 16-bit slice at a time through a narrow port. A 2-bit slice index picks the slice.

The mask can also slide by one bit position per shift request, left or right. The slide stays between a lower and an upper bit index, which mark the compare partition of the word. It does not wrap. The bit at the leading limit keeps its value and is copied into its neighbour, so a run of ones or zeros grows from that edge. Bits outside the limits are never touched by a slide.

The masked-compare result and the masked-merge result are both combinational functions of the registered mask. A caller supplies a data word and a key, or an old and a new word, and uses the result in the same cycle.

Top module: `slide_mask_reg`

## Requirements
- R1: While rst_n is low, mask_q is all zeros. Reset is asynchronous and active low.
- R2: A segment write (seg_wr_en=1) loads seg_wdata into mask bits [16*s+15 : 16*s], where s is the value of seg_sel. The new value appears at the next rising clock edge, and the other three slices keep their values.
- R3: When seg_wr_en and shift_en are both 1 in the same cycle, only the segment write takes effect. The shift request is dropped.
- R4: A right shift (shift_en=1, shift_dir=0, seg_wr_en=0) with lim_lo < lim_hi works as follows: every bit i with lim_lo <= i < lim_hi takes the old value of bit i+1, and bit lim_hi keeps its value.
- R5: A left shift (shift_en=1, shift_dir=1, seg_wr_en=0) with lim_lo < lim_hi works as follows: every bit i with lim_lo < i <= lim_hi takes the old value of bit i-1, and bit lim_lo keeps its value.
- R6: A shift changes no bit outside the range lim_lo..lim_hi. When lim_lo >= lim_hi, a shift leaves the whole mask unchanged.
- R7: cmp_hit is 1 exactly when cmp_data equals cmp_key at every bit position whose mask bit is 0. Positions whose mask bit is 1 are ignored. The result follows mask_q in the same cycle.
- R8: Each bit of merge_out equals merge_new where the mask bit is 0 and merge_old where the mask bit is 1, in the same cycle.
- R9: When both seg_wr_en and shift_en are 0, mask_q holds its value.
- R10: Each shift request moves the mask by exactly one position, so two successive right shifts copy bit i+2 into bit i, within the limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Load one 16-bit slice of the mask |
| seg_sel | input | 2 | Slice index; slice s is bits 16*s+15..16*s |
| seg_wdata | input | 16 | Slice value to load |
| shift_en | input | 1 | Slide the mask one position |
| shift_dir | input | 1 | 0 = right (towards bit 0), 1 = left |
| lim_lo | input | 6 | Lowest bit index of the partition |
| lim_hi | input | 6 | Highest bit index of the partition |
| cmp_data | input | 64 | Word under test for the masked compare |
| cmp_key | input | 64 | Reference word for the masked compare |
| merge_old | input | 64 | Current destination contents |
| merge_new | input | 64 | Incoming data for the masked merge |
| mask_q | output | 64 | Registered mask |
| cmp_hit | output | 1 | Masked compare result |
| merge_out | output | 64 | Masked merge of new over old |

## Verification
The bench slides a mask that holds lone set bits at and near the partition edges. A design that wraps the edge bit, or that moves the limit bit instead of holding it, would show a one reappearing at the far edge or a hole at the limit. It also uses a single-bit partition and an inverted (empty) partition, where any bit that moves points to wrong range decoding. It raises a write and a shift together to expose a priority mix-up. It then probes the compare with mismatches placed only under ones in the mask, and again with one added mismatch under a zero, so that a swapped mask polarity flips cmp_hit.

// File: rtl/slide_mask_pkg.sv
package slide_mask_pkg;
   typedef enum logic {
      DIR_RIGHT = 1'b0,
      DIR_LEFT  = 1'b1
   } shift_dir_e;
endpackage

// File: rtl/slide_mask_seg.sv
// Builds the next mask value for a slice load: one slice replaced, rest kept.
module slide_mask_seg #(
   parameter int DATA_W = 64,
   parameter int SEG_W  = 16,
   parameter int SEL_W  = 2
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [SEG_W-1:0]  wdata,
   input  logic [DATA_W-1:0] cur,
   output logic [DATA_W-1:0] nxt
);
   localparam int NSEG = DATA_W / SEG_W;

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      localparam logic [SEL_W-1:0] SIDX = SEL_W'(s);
      assign nxt[s*SEG_W +: SEG_W] = (sel == SIDX) ? wdata : cur[s*SEG_W +: SEG_W];
   end
endmodule

// File: rtl/slide_mask_shift.sv
// One-position slide inside [lo, hi] with the leading limit bit replicated.
module slide_mask_shift
   import slide_mask_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int IDX_W  = 6
) (
   input  logic [DATA_W-1:0] cur,
   input  logic [IDX_W-1:0]  lo,
   input  logic [IDX_W-1:0]  hi,
   input  shift_dir_e        dir,
   output logic [DATA_W-1:0] nxt
);
   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [IDX_W-1:0] IDX = IDX_W'(i);
      logic in_part;
      logic from_up;
      logic from_dn;
      assign in_part = (lo <= IDX) && (IDX <= hi);

      if (i == DATA_W - 1) begin : g_top
         assign from_up = cur[i];
      end else begin : g_mid_up
         assign from_up = (in_part && (IDX != hi)) ? cur[i+1] : cur[i];
      end

      if (i == 0) begin : g_bot
         assign from_dn = cur[i];
      end else begin : g_mid_dn
         assign from_dn = (in_part && (IDX != lo)) ? cur[i-1] : cur[i];
      end

      assign nxt[i] = (dir == DIR_LEFT) ? from_dn : from_up;
   end
endmodule

// File: rtl/slide_mask_cmp.sv
// Masked compare and masked merge, both purely combinational.
module slide_mask_cmp #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] data,
   input  logic [DATA_W-1:0] key,
   input  logic [DATA_W-1:0] old_w,
   input  logic [DATA_W-1:0] new_w,
   output logic              hit,
   output logic [DATA_W-1:0] merged
);
   logic [DATA_W-1:0] bit_ok;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      assign bit_ok[i] = mask[i] | (data[i] ~^ key[i]);
      assign merged[i] = mask[i] ? old_w[i] : new_w[i];
   end

   assign hit = &bit_ok;
endmodule

// File: rtl/slide_mask_reg.sv
module slide_mask_reg
   import slide_mask_pkg::*;
#(
   parameter int DATA_W = 64,
   parameter int SEG_W  = 16,
   parameter int SEL_W  = 2,
   parameter int IDX_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              seg_wr_en,
   input  logic [SEL_W-1:0]  seg_sel,
   input  logic [SEG_W-1:0]  seg_wdata,
   input  logic              shift_en,
   input  logic              shift_dir,
   input  logic [IDX_W-1:0]  lim_lo,
   input  logic [IDX_W-1:0]  lim_hi,
   input  logic [DATA_W-1:0] cmp_data,
   input  logic [DATA_W-1:0] cmp_key,
   input  logic [DATA_W-1:0] merge_old,
   input  logic [DATA_W-1:0] merge_new,
   output logic [DATA_W-1:0] mask_q,
   output logic              cmp_hit,
   output logic [DATA_W-1:0] merge_out
);
   localparam int NSEG = DATA_W / SEG_W;

   if (DATA_W % SEG_W != 0) begin : g_bad_seg
      $error("DATA_W must be a multiple of SEG_W");
   end
   if ((1 << SEL_W) != NSEG) begin : g_bad_sel
      $error("SEL_W must index exactly DATA_W/SEG_W slices");
   end
   if ((1 << IDX_W) != DATA_W) begin : g_bad_idx
      $error("IDX_W must index exactly DATA_W bits");
   end

   logic [DATA_W-1:0] seg_nxt;
   logic [DATA_W-1:0] shf_nxt;
   shift_dir_e        dir_e;

   assign dir_e = shift_dir_e'(shift_dir);

   slide_mask_seg #(.DATA_W(DATA_W), .SEG_W(SEG_W), .SEL_W(SEL_W)) u_seg (
      .sel   (seg_sel),
      .wdata (seg_wdata),
      .cur   (mask_q),
      .nxt   (seg_nxt)
   );

   slide_mask_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
      .cur (mask_q),
      .lo  (lim_lo),
      .hi  (lim_hi),
      .dir (dir_e),
      .nxt (shf_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (seg_wr_en) begin
         mask_q <= seg_nxt;
      end else if (shift_en) begin
         mask_q <= shf_nxt;
      end
   end

   slide_mask_cmp #(.DATA_W(DATA_W)) u_cmp (
      .mask   (mask_q),
      .data   (cmp_data),
      .key    (cmp_key),
      .old_w  (merge_old),
      .new_w  (merge_new),
      .hit    (cmp_hit),
      .merged (merge_out)
   );
endmodule

// File: rtl/slide_mask_chk.sv
module slide_mask_chk #(
   parameter int DATA_W = 64,
   parameter int SEG_W  = 16,
   parameter int SEL_W  = 2,
   parameter int IDX_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seg_wr_en,
   input logic [SEL_W-1:0]  seg_sel,
   input logic [SEG_W-1:0]  seg_wdata,
   input logic              shift_en,
   input logic              shift_dir,
   input logic [IDX_W-1:0]  lim_lo,
   input logic [IDX_W-1:0]  lim_hi,
   input logic [DATA_W-1:0] cmp_data,
   input logic [DATA_W-1:0] cmp_key,
   input logic [DATA_W-1:0] merge_old,
   input logic [DATA_W-1:0] merge_new,
   input logic [DATA_W-1:0] mask_q,
   input logic              cmp_hit,
   input logic [DATA_W-1:0] merge_out
);
   logic [DATA_W-1:0] seg_span;
   logic [DATA_W-1:0] part_span;
   logic              shr_ok;
   logic              shl_ok;

   assign seg_span = {{(DATA_W-SEG_W){1'b0}}, {SEG_W{1'b1}}} << (int'(seg_sel) * SEG_W);
   assign shr_ok   = shift_en && !seg_wr_en && !shift_dir && (lim_lo < lim_hi);
   assign shl_ok   = shift_en && !seg_wr_en &&  shift_dir && (lim_lo < lim_hi);

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         part_span[i] = (int'(lim_lo) <= i) && (i <= int'(lim_hi));
      end
   end

   p_reset_zero_r1: assert property (@(posedge clk) !rst_n |-> (mask_q == '0));

   p_seg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      seg_wr_en |=> (mask_q[int'($past(seg_sel))*SEG_W +: SEG_W] == $past(seg_wdata)));

   p_seg_others_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_wr_en && !shift_en) |=> ((mask_q & ~$past(seg_span)) == ($past(mask_q) & ~$past(seg_span))));

   p_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_wr_en && shift_en) |=> ((mask_q & ~$past(seg_span)) == ($past(mask_q) & ~$past(seg_span))));

   p_shr_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shr_ok |=> (mask_q[$past(lim_hi)] == $past(mask_q[lim_hi])));

   p_shr_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shr_ok |=> (mask_q[$past(lim_lo)] == $past(mask_q[int'(lim_lo) + 1])));

   p_shl_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shl_ok |=> (mask_q[$past(lim_lo)] == $past(mask_q[lim_lo])));

   p_shl_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shl_ok |=> (mask_q[$past(lim_hi)] == $past(mask_q[int'(lim_hi) - 1])));

   p_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !seg_wr_en) |=> ((mask_q & ~$past(part_span)) == ($past(mask_q) & ~$past(part_span))));

   p_empty_part_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_en && !seg_wr_en && (lim_lo >= lim_hi)) |=> $stable(mask_q));

   p_cmp_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit |-> (((cmp_data ^ cmp_key) & ~mask_q) == '0));

   p_cmp_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_hit |-> (((cmp_data ^ cmp_key) & ~mask_q) != '0));

   p_merge_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (((merge_out ^ merge_old) & mask_q) == '0));

   p_merge_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (((merge_out ^ merge_new) & ~mask_q) == '0));

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!seg_wr_en && !shift_en) |=> $stable(mask_q));
endmodule

bind slide_mask_reg slide_mask_chk #(
   .DATA_W(DATA_W), .SEG_W(SEG_W), .SEL_W(SEL_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/slide_mask_reg_tb.sv
module slide_mask_reg_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 64;
   localparam int NVEC = 14;

   // vector: {both, op[1:0], sel[1:0], data[15:0], lo[5:0], hi[5:0]}
   // op: 0 idle, 1 slice write, 2 shift right, 3 shift left
   localparam logic [32:0] VEC [NVEC] = '{
      {1'b0, 2'd1, 2'd0, 16'h0001, 6'd0,  6'd0},
      {1'b0, 2'd1, 2'd3, 16'h8000, 6'd0,  6'd0},
      {1'b0, 2'd1, 2'd1, 16'h00F0, 6'd0,  6'd0},
      {1'b0, 2'd2, 2'd0, 16'h0000, 6'd0,  6'd63},
      {1'b0, 2'd3, 2'd0, 16'h0000, 6'd4,  6'd20},
      {1'b0, 2'd2, 2'd0, 16'h0000, 6'd10, 6'd40},
      {1'b0, 2'd3, 2'd0, 16'h0000, 6'd0,  6'd63},
      {1'b1, 2'd1, 2'd2, 16'hA5A5, 6'd0,  6'd63},
      {1'b0, 2'd2, 2'd0, 16'h0000, 6'd30, 6'd30},
      {1'b0, 2'd3, 2'd0, 16'h0000, 6'd50, 6'd20},
      {1'b0, 2'd0, 2'd0, 16'h0000, 6'd0,  6'd63},
      {1'b0, 2'd1, 2'd0, 16'hFF00, 6'd0,  6'd0},
      {1'b0, 2'd2, 2'd0, 16'h0000, 6'd0,  6'd15},
      {1'b0, 2'd2, 2'd0, 16'h0000, 6'd0,  6'd15}
   };

   logic          clk = 1'b0;
   logic          rst_n;
   logic          seg_wr_en = 1'b0;
   logic [1:0]    seg_sel = '0;
   logic [15:0]   seg_wdata = '0;
   logic          shift_en = 1'b0;
   logic          shift_dir = 1'b0;
   logic [5:0]    lim_lo = '0;
   logic [5:0]    lim_hi = '0;
   logic [DW-1:0] cmp_data = '0;
   logic [DW-1:0] cmp_key = '0;
   logic [DW-1:0] merge_old = '0;
   logic [DW-1:0] merge_new = '0;
   logic [DW-1:0] mask_q;
   logic          cmp_hit;
   logic [DW-1:0] merge_out;

   int            checks = 0;
   int            failures = 0;
   logic [DW-1:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   slide_mask_reg u_dut (
      .clk(clk), .rst_n(rst_n), .seg_wr_en(seg_wr_en), .seg_sel(seg_sel),
      .seg_wdata(seg_wdata), .shift_en(shift_en), .shift_dir(shift_dir),
      .lim_lo(lim_lo), .lim_hi(lim_hi), .cmp_data(cmp_data), .cmp_key(cmp_key),
      .merge_old(merge_old), .merge_new(merge_new), .mask_q(mask_q),
      .cmp_hit(cmp_hit), .merge_out(merge_out)
   );

   task automatic check_vec(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic model_hit(logic [DW-1:0] m, logic [DW-1:0] d, logic [DW-1:0] k);
      logic h = 1'b1;
      for (int i = 0; i < DW; i++) if (!m[i] && (d[i] != k[i])) h = 1'b0;
      return h;
   endfunction

   function automatic logic [DW-1:0] model_merge(logic [DW-1:0] m, logic [DW-1:0] o, logic [DW-1:0] n);
      logic [DW-1:0] r;
      for (int i = 0; i < DW; i++) r[i] = m[i] ? o[i] : n[i];
      return r;
   endfunction

   function automatic logic [DW-1:0] model_step(logic [DW-1:0] m, logic [32:0] v);
      logic [DW-1:0] r = m;
      int lo = int'(v[11:6]);
      int hi = int'(v[5:0]);
      case (v[31:30])
         2'd1: r[int'(v[29:28])*16 +: 16] = v[27:12];
         2'd2: if (lo < hi) for (int i = lo; i < hi; i++) r[i] = m[i+1];
         2'd3: if (lo < hi) for (int i = lo + 1; i <= hi; i++) r[i] = m[i-1];
         default: ;
      endcase
      return r;
   endfunction

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_vec("R1 reset", mask_q, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: every step checks mask, compare and merge
      for (int s = 0; s < NVEC; s++) begin
         logic [32:0] v = VEC[s];
         logic [DW-1:0] key = 64'h0123_4567_89AB_CDEF ^ {32'(s), 32'(s * 7)};
         logic [DW-1:0] flip = (64'h1 << (s * 4)) | (64'h1 << 63);
         string req;
         case (v[31:30])
            2'd1: req = v[32] ? "R3 write beats shift" : "R2 slice write";
            2'd2: req = (v[11:6] < v[5:0]) ? "R4 shift right" : "R6 empty partition";
            2'd3: req = (v[11:6] < v[5:0]) ? "R5 shift left" : "R6 empty partition";
            default: req = "R9 idle hold";
         endcase
         if (s == 13) req = "R10 one position per shift";
         seg_wr_en = (v[31:30] == 2'd1);
         shift_en  = (v[31:30] >= 2'd2) || v[32];
         shift_dir = (v[31:30] == 2'd3);
         seg_sel   = v[29:28];
         seg_wdata = v[27:12];
         lim_lo    = v[11:6];
         lim_hi    = v[5:0];
         model     = model_step(model, v);
         @(negedge clk);
         seg_wr_en = 1'b0;
         shift_en  = 1'b0;
         check_vec(req, mask_q, model);
         cmp_key   = key;
         cmp_data  = key ^ flip;
         merge_old = ~key;
         merge_new = key;
         #1;
         check_vec("R7 masked compare", {63'd0, cmp_hit}, {63'd0, model_hit(model, key ^ flip, key)});
         check_vec("R8 masked merge", merge_out, model_merge(model, ~key, key));
      end

      // R4 edge: bit 63 set, right shift over full range keeps it and copies down
      seg_wr_en = 1'b1; seg_sel = 2'd3; seg_wdata = 16'h8000;
      @(negedge clk);
      seg_wr_en = 1'b1; seg_sel = 2'd0; seg_wdata = 16'h0000;
      @(negedge clk);
      seg_wr_en = 1'b0;
      shift_en = 1'b1; shift_dir = 1'b0; lim_lo = 6'd0; lim_hi = 6'd63;
      @(negedge clk);
      shift_en = 1'b0;
      model = mask_q;
      check_vec("R4 limit bit replicated no wrap", {mask_q[63:60], mask_q[0]}, {4'b1100, 1'b0});

      // R5 edge: lowest partition bit replicated upward, not wrapped to hi
      seg_wr_en = 1'b1; seg_sel = 2'd0; seg_wdata = 16'h0011;
      @(negedge clk);
      seg_wr_en = 1'b0;
      shift_en = 1'b1; shift_dir = 1'b1; lim_lo = 6'd4; lim_hi = 6'd7;
      @(negedge clk);
      shift_en = 1'b0;
      check_vec("R5 lower limit replicated", {48'd0, mask_q[15:0]}, 64'h0000_0000_0000_0031);

      // R7 directed: mismatches only under masked bits -> hit; one more under a zero -> miss
      cmp_key  = 64'hDEAD_BEEF_F00D_CAFE;
      cmp_data = cmp_key ^ mask_q;
      #1;
      check_vec("R7 masked mismatch ignored", {63'd0, cmp_hit}, 64'd1);
      cmp_data = cmp_key ^ mask_q ^ 64'h2;
      #1;
      check_vec("R7 unmasked mismatch misses", {63'd0, cmp_hit}, 64'd0);

      // R8 directed: all ones old, zeros new -> output equals mask
      merge_old = '1; merge_new = '0;
      #1;
      check_vec("R8 merge keeps masked bits", merge_out, mask_q);

      // R1: asynchronous reset mid-run
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_vec("R1 async reset clears", mask_q, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_vec("R1 stays clear after reset", mask_q, '0);

      finish_run();
   end
endmodule